// File: doc/BRIEF.md
# Slave-Mode DMA Transfer Engine

This block paces a slave-mode DMA transfer between a local data buffer and an external DMA bus. A configuration write sets how the bus is used. It picks which strobe pins carry the data handshakes, whether each handshake moves one or two bytes, and whether the byte counter can end a transfer. It also sets the active level of every handshake pin. The remaining byte count is loaded separately. A command write then starts a read transfer, in which data leaves the engine, or a write transfer, in which data enters it.

During a transfer the engine raises its request output once for each individual transfer. It takes back the request as soon as the selected strobe arrives. It re-raises the request only after that strobe has gone inactive again. Every accepted strobe lowers the remaining count. The transfer ends when the count runs out or when the end-of-transfer pin becomes active. A one-cycle done pulse reports the end, tagged with its cause. The external data bus stays released until a read command is running. The request pin is not driven until the engine has been configured once.

Top module: `gdma_slave_engine`

## Requirements
- R1: After reset the engine is idle: `busy`, `data_oe`, `dreq_oe` and `done_pulse` are 0 and `remaining` is 0.
- R2: While idle, a command write with code 0 starts a read transfer and code 1 starts a write transfer. Any other code, and any command written while busy, has no effect.
- R3: Each accepted strobe lowers `remaining` by 1 when `cfg_wide` is 0 and by 2 when it is 1, and pulses `xfer_stb`. `cnt_wdata` is loaded on `cnt_wr` only while idle.
- R4: With the counter enabled (`cfg_cnt_dis`=0), the strobe that brings the count to zero ends the transfer with cause COUNT. A 2-byte step on a count of 1 leaves 0. A start with a count of 0 ends at once with cause COUNT.
- R5: With `cfg_cnt_dis`=1 the counter keeps decrementing and wraps past zero (0 minus 1 gives all ones), and reaching zero does not end the transfer.
- R6: An inactive-to-active change of the end-of-transfer pin during a transfer ends it with cause EOT and leaves `remaining` as it was. If it coincides with the terminal strobe, EOT is reported.
- R7: Strobe selection by `cfg_mode`: 00 takes reads on the read strobe and writes on the write strobe. 01 takes reads on the read strobe and writes on the acknowledge pin. 10 takes both directions on the acknowledge pin. 11 acts as 00. A strobe on a pin that is not selected has no effect.
- R8: `cfg_pol` bit 0 (read strobe), bit 1 (write strobe), bit 2 (acknowledge), bit 3 (end of transfer) and bit 4 (request) give each pin's active level: 1 for active high, 0 for active low.
- R9: `data_oe` is 1 only while a read transfer is running. It is 0 when idle and during write transfers.
- R10: `dreq_oe` stays 0 until the first configuration write and stays 1 from then on. While idle `dreq_o` holds its inactive level.
- R11: `dreq_o` goes active when a transfer starts. It goes inactive after each accepted strobe and returns to active only once that strobe pin is inactive again and the transfer goes on.
- R12: `done_pulse` lasts one cycle per finished transfer. `done_cause` bit 0 marks COUNT and bit 1 marks EOT, with exactly one bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_mode | input | 2 | Strobe-mode selection |
| cfg_wide | input | 1 | 1: two bytes per strobe; 0: one byte |
| cfg_cnt_dis | input | 1 | 1: counter cannot end a transfer |
| cfg_pol | input | 5 | Active-level bits for the pins (see R8) |
| cnt_wr | input | 1 | Byte-count load strobe |
| cnt_wdata | input | CNT_W | Byte count to load |
| cmd_wr | input | 1 | Command write strobe |
| cmd_code | input | 8 | Command code |
| dior_i | input | 1 | Read strobe pin |
| diow_i | input | 1 | Write strobe pin |
| dack_i | input | 1 | Acknowledge pin |
| eot_i | input | 1 | End-of-transfer pin |
| dreq_o | output | 1 | Request pin level |
| dreq_oe | output | 1 | Request pin driver enable |
| data_oe | output | 1 | External data bus driver enable |
| xfer_stb | output | 1 | One pulse per accepted strobe |
| busy | output | 1 | Transfer running |
| remaining | output | CNT_W | Remaining byte count |
| done_pulse | output | 1 | Transfer-finished pulse |
| done_cause | output | 2 | Cause of finish: bit 0 COUNT, bit 1 EOT |

## Verification
The bench targets the odd count under 2-byte steps: a design that subtracts blindly would wrap to all ones and keep running. It also targets the wrap with the counter disabled: a design that ends there would stop a transfer that only EOT should end. Strobes are driven on pins the current mode does not select, so a design that decodes the strobe mode wrongly would count bytes it should ignore. Tests with inverted polarity, and a check that the request drops while a strobe is still held, expose engines that apply the active level to one pin only. They also expose engines that raise the request again before the handshake is complete.

// File: rtl/gdma_pkg.sv
package gdma_pkg;

  typedef enum logic [1:0] {
    STB_RD_WR    = 2'b00,
    STB_RD_ACK   = 2'b01,
    STB_ACK_ONLY = 2'b10,
    STB_RSVD     = 2'b11
  } strobe_mode_e;

  // Pin slot numbering used across the block.
  localparam int PIN_RD  = 0;
  localparam int PIN_WR  = 1;
  localparam int PIN_ACK = 2;
  localparam int PIN_EOT = 3;
  localparam int N_PINS  = 4;

  localparam logic [7:0] CMD_READ  = 8'h00;
  localparam logic [7:0] CMD_WRITE = 8'h01;

  localparam logic [1:0] CAUSE_COUNT = 2'b01;
  localparam logic [1:0] CAUSE_EOT   = 2'b10;

  typedef struct packed {
    strobe_mode_e mode;
    logic         wide;
    logic         cnt_dis;
    logic [4:0]   pol;
  } cfg_t;

  // One-hot selection over {ack, wr, rd} for the given mode and direction.
  function automatic logic [2:0] strobe_pick(input strobe_mode_e m, input logic is_write);
    case (m)
      STB_RD_ACK:   strobe_pick = is_write ? 3'b100 : 3'b001;
      STB_ACK_ONLY: strobe_pick = 3'b100;
      default:      strobe_pick = is_write ? 3'b010 : 3'b001;
    endcase
  endfunction

  function automatic logic cmd_valid(input logic [7:0] code);
    cmd_valid = (code == CMD_READ) || (code == CMD_WRITE);
  endfunction

endpackage

// File: rtl/gdma_pin_sync.sv
module gdma_pin_sync #(
  parameter int N           = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] raw,
  input  logic [N-1:0] pol,
  output logic [N-1:0] level,
  output logic [N-1:0] rise
);
  logic [N-1:0] prev_q;

  for (genvar i = 0; i < N; i++) begin : g_pin
    logic [SYNC_STAGES-1:0] chain_q;
    logic                   act;
    // Active level in the engine's own sense: 1 means asserted.
    assign act = ~(raw[i] ^ pol[i]);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[SYNC_STAGES-2:0], act};
    end
    assign level[i] = chain_q[SYNC_STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= level;
  end

  assign rise = level & ~prev_q;
endmodule

// File: rtl/gdma_byte_counter.sv
module gdma_byte_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             step_en,
  input  logic             wide,
  input  logic             cnt_dis,
  output logic [CNT_W-1:0] count,
  output logic             terminal,
  output logic             is_zero
);
  function automatic logic [CNT_W-1:0] step_of(input logic w);
    step_of = w ? CNT_W'(2) : CNT_W'(1);
  endfunction

  // Enabled counter floors at zero; disabled counter wraps freely.
  function automatic logic [CNT_W-1:0] next_of(input logic [CNT_W-1:0] c,
                                               input logic w, input logic dis);
    if (!dis && (c < step_of(w))) next_of = '0;
    else                          next_of = c - step_of(w);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       count <= '0;
    else if (load)    count <= load_val;
    else if (step_en) count <= next_of(count, wide, cnt_dis);
  end

  assign terminal = !cnt_dis && (count <= step_of(wide));
  assign is_zero  = (count == '0);
endmodule

// File: rtl/gdma_xfer_ctrl.sv
module gdma_xfer_ctrl
  import gdma_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cmd_wr,
  input  logic [7:0]   cmd_code,
  input  strobe_mode_e mode,
  input  logic         cnt_dis,
  input  logic [2:0]   stb_level,
  input  logic [2:0]   stb_rise,
  input  logic         eot_rise,
  input  logic         cnt_terminal,
  input  logic         cnt_zero,
  output logic         busy,
  output logic         dir_write,
  output logic         req_active,
  output logic         stb_accept,
  output logic         done,
  output logic [1:0]   cause
);
  logic [2:0] sel;
  logic       start_ok, end_cnt, end_eot;

  assign sel        = strobe_pick(mode, dir_write);
  assign start_ok   = cmd_wr && !busy && cmd_valid(cmd_code);
  assign stb_accept = busy && |(stb_rise & sel);
  assign end_cnt    = stb_accept && cnt_terminal;
  assign end_eot    = busy && eot_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      dir_write  <= 1'b0;
      req_active <= 1'b0;
      done       <= 1'b0;
      cause      <= '0;
    end else begin
      done <= 1'b0;
      if (start_ok) begin
        dir_write <= cmd_code[0];
        if (!cnt_dis && cnt_zero) begin
          done  <= 1'b1;
          cause <= CAUSE_COUNT;
        end else begin
          busy       <= 1'b1;
          req_active <= 1'b1;
        end
      end else if (busy) begin
        if (end_eot || end_cnt) begin
          busy       <= 1'b0;
          req_active <= 1'b0;
          done       <= 1'b1;
          cause      <= end_eot ? CAUSE_EOT : CAUSE_COUNT;
        end else if (stb_accept) begin
          req_active <= 1'b0;
        end else if (!req_active && !(|(stb_level & sel))) begin
          req_active <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/gdma_slave_engine.sv
module gdma_slave_engine
  import gdma_pkg::*;
#(
  parameter int CNT_W       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [1:0]       cfg_mode,
  input  logic             cfg_wide,
  input  logic             cfg_cnt_dis,
  input  logic [4:0]       cfg_pol,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] cnt_wdata,
  input  logic             cmd_wr,
  input  logic [7:0]       cmd_code,
  input  logic             dior_i,
  input  logic             diow_i,
  input  logic             dack_i,
  input  logic             eot_i,
  output logic             dreq_o,
  output logic             dreq_oe,
  output logic             data_oe,
  output logic             xfer_stb,
  output logic             busy,
  output logic [CNT_W-1:0] remaining,
  output logic             done_pulse,
  output logic [1:0]       done_cause
);
  cfg_t             cfg_q;
  logic             cfg_seen_q;
  logic [N_PINS-1:0] pin_raw, pin_pol, pin_level, pin_rise;
  logic             req_active, stb_accept, dir_write;
  logic             cnt_terminal, cnt_zero, cfg_cnt_dis_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q      <= '0;
      cfg_seen_q <= 1'b0;
    end else if (cfg_wr) begin
      cfg_q      <= '{mode: strobe_mode_e'(cfg_mode), wide: cfg_wide,
                      cnt_dis: cfg_cnt_dis, pol: cfg_pol};
      cfg_seen_q <= 1'b1;
    end
  end

  assign pin_raw = {eot_i, dack_i, diow_i, dior_i};
  assign pin_pol = cfg_q.pol[3:0];
  assign cfg_cnt_dis_w = cfg_q.cnt_dis;

  gdma_pin_sync #(.N(N_PINS), .SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .raw(pin_raw), .pol(pin_pol),
    .level(pin_level), .rise(pin_rise)
  );

  gdma_byte_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(cnt_wr && !busy), .load_val(cnt_wdata),
    .step_en(stb_accept), .wide(cfg_q.wide), .cnt_dis(cfg_q.cnt_dis),
    .count(remaining), .terminal(cnt_terminal), .is_zero(cnt_zero)
  );

  gdma_xfer_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_code(cmd_code),
    .mode(cfg_q.mode), .cnt_dis(cfg_q.cnt_dis),
    .stb_level(pin_level[PIN_ACK:PIN_RD]), .stb_rise(pin_rise[PIN_ACK:PIN_RD]),
    .eot_rise(pin_rise[PIN_EOT]), .cnt_terminal(cnt_terminal), .cnt_zero(cnt_zero),
    .busy(busy), .dir_write(dir_write), .req_active(req_active),
    .stb_accept(stb_accept), .done(done_pulse), .cause(done_cause)
  );

  assign dreq_o   = cfg_q.pol[4] ? req_active : ~req_active;
  assign dreq_oe  = cfg_seen_q;
  assign data_oe  = busy && !dir_write;
  assign xfer_stb = stb_accept;
endmodule

// File: rtl/gdma_slave_engine_chk.sv
module gdma_slave_engine_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             data_oe,
  input logic             dreq_oe,
  input logic             req_active,
  input logic             stb_accept,
  input logic             cnt_dis,
  input logic [CNT_W-1:0] remaining,
  input logic             done_pulse,
  input logic [1:0]       done_cause
);
  p_cause_onehot_r12: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |-> ($countones(done_cause) == 1));
  p_done_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |-> !busy);
  p_bus_needs_xfer_r9: assert property (@(posedge clk) disable iff (!rst_n)
    data_oe |-> busy);
  p_req_oe_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    dreq_oe |=> dreq_oe);
  p_req_needs_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    req_active |-> busy);
  p_accept_drops_req_r11: assert property (@(posedge clk) disable iff (!rst_n)
    stb_accept |=> !req_active);
  p_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (stb_accept && cnt_dis && remaining == '0) |=> (remaining >= {CNT_W{1'b1}} - CNT_W'(1)));
  p_count_moves_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (stb_accept && cnt_dis) |=> (remaining != $past(remaining)));
endmodule

bind gdma_slave_engine gdma_slave_engine_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .data_oe(data_oe), .dreq_oe(dreq_oe),
  .req_active(req_active), .stb_accept(stb_accept), .cnt_dis(cfg_cnt_dis_w),
  .remaining(remaining), .done_pulse(done_pulse), .done_cause(done_cause)
);

// File: tb/gdma_slave_engine_bench.sv
module gdma_slave_engine_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 32;

  logic clk = 0, rst_n = 0;
  logic cfg_wr = 0, cfg_wide = 0, cfg_cnt_dis = 0;
  logic [1:0] cfg_mode = 0;
  logic [4:0] cfg_pol = 0;
  logic cnt_wr = 0, cmd_wr = 0;
  logic [CW-1:0] cnt_wdata = 0;
  logic [7:0] cmd_code = 0;
  logic [3:0] act = 0;     // {eot, ack, wr, rd} asserted in the engine's sense
  logic [4:0] pol = 0;     // bench mirror of the pin active levels
  logic dior_i, diow_i, dack_i, eot_i;
  logic dreq_o, dreq_oe, data_oe, xfer_stb, busy, done_pulse;
  logic [CW-1:0] remaining;
  logic [1:0] done_cause;
  int tests = 0, fails = 0, n_done = 0;
  logic [1:0] last_cause = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign dior_i = ~(act[0] ^ pol[0]);
  assign diow_i = ~(act[1] ^ pol[1]);
  assign dack_i = ~(act[2] ^ pol[2]);
  assign eot_i  = ~(act[3] ^ pol[3]);

  gdma_slave_engine u_gdma_slave_engine (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_mode(cfg_mode), .cfg_wide(cfg_wide),
    .cfg_cnt_dis(cfg_cnt_dis), .cfg_pol(cfg_pol), .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata),
    .cmd_wr(cmd_wr), .cmd_code(cmd_code), .dior_i(dior_i), .diow_i(diow_i),
    .dack_i(dack_i), .eot_i(eot_i), .dreq_o(dreq_o), .dreq_oe(dreq_oe),
    .data_oe(data_oe), .xfer_stb(xfer_stb), .busy(busy), .remaining(remaining),
    .done_pulse(done_pulse), .done_cause(done_cause)
  );

  always @(posedge clk) if (rst_n && done_pulse) begin
    n_done = n_done + 1;
    last_cause = done_cause;
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [CW-1:0] got, input logic [CW-1:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  function automatic logic req_lvl(input logic a);
    return pol[4] ? a : ~a;
  endfunction

  task automatic configure(input logic [1:0] m, input logic w, input logic dis, input logic [4:0] p);
    pol = p; cfg_mode = m; cfg_wide = w; cfg_cnt_dis = dis; cfg_pol = p; cfg_wr = 1;
    cyc(1); cfg_wr = 0; cyc(4);
  endtask

  task automatic load(input logic [CW-1:0] v);
    cnt_wdata = v; cnt_wr = 1; cyc(1); cnt_wr = 0; cyc(1);
  endtask

  task automatic command(input logic [7:0] c);
    cmd_code = c; cmd_wr = 1; cyc(1); cmd_wr = 0; cyc(2);
  endtask

  // Hold a pin active, optionally check the request drops mid-strobe, release.
  task automatic pulse_pin(input int idx, input bit chk_drop);
    act[idx] = 1; cyc(5);
    if (chk_drop) check("R11 request drops during strobe", dreq_o, req_lvl(0));
    act[idx] = 0; cyc(5);
  endtask

  task automatic t_reset;
    check("R1 busy", busy, 0);
    check("R1 data_oe", data_oe, 0);
    check("R10 dreq_oe before config", dreq_oe, 0);
    check("R1 remaining", remaining, 0);
    check("R1 done", done_pulse, 0);
  endtask

  task automatic t_read8;
    int d0;
    configure(2'b00, 0, 0, 5'b11111);
    check("R10 dreq_oe after config", dreq_oe, 1);
    check("R10 idle request level", dreq_o, req_lvl(0));
    load(3); command(8'h00);
    check("R2 read starts", busy, 1);
    check("R9 data_oe in read", data_oe, 1);
    check("R11 request on start", dreq_o, req_lvl(1));
    pulse_pin(1, 0);
    check("R7 unselected write strobe ignored", remaining, 3);
    d0 = n_done;
    pulse_pin(0, 1);
    check("R3 8-bit step", remaining, 2);
    check("R11 request returns", dreq_o, req_lvl(1));
    pulse_pin(0, 0); pulse_pin(0, 0);
    check("R4 count end remaining", remaining, 0);
    check("R4 busy cleared", busy, 0);
    check("R12 one done pulse", n_done - d0, 1);
    check("R12 cause COUNT", last_cause, 2'b01);
    check("R9 data_oe released", data_oe, 0);
  endtask

  task automatic t_bad_cmd;
    load(4); command(8'h05);
    check("R2 invalid code ignored", busy, 0);
  endtask

  task automatic t_write16;
    configure(2'b01, 1, 0, 5'b11111);
    load(5); command(8'h01);
    check("R2 write starts", busy, 1);
    check("R9 data_oe off in write", data_oe, 0);
    command(8'h00);
    check("R2 command while busy ignored", data_oe, 0);
    pulse_pin(0, 0);
    check("R7 mode01 read strobe ignored on write", remaining, 5);
    pulse_pin(2, 1);
    check("R3 16-bit step", remaining, 3);
    pulse_pin(2, 0); pulse_pin(2, 0);
    check("R4 odd count ends at zero", remaining, 0);
    check("R4 ended", busy, 0);
    check("R12 cause COUNT", last_cause, 2'b01);
  endtask

  task automatic t_eot;
    configure(2'b10, 0, 0, 5'b11111);
    load(10); command(8'h00);
    pulse_pin(2, 0);
    check("R7 mode10 ack read", remaining, 9);
    pulse_pin(3, 0);
    check("R6 EOT ends", busy, 0);
    check("R6 cause EOT", last_cause, 2'b10);
    check("R6 count kept", remaining, 9);
  endtask

  task automatic t_cnt_dis;
    configure(2'b00, 0, 1, 5'b11111);
    load(1); command(8'h01);
    pulse_pin(1, 0);
    check("R5 reaches zero", remaining, 0);
    check("R5 no end at zero", busy, 1);
    pulse_pin(1, 0);
    check("R5 wraps", remaining, 32'hFFFF_FFFF);
    check("R5 still running", busy, 1);
    pulse_pin(3, 0);
    check("R6 EOT ends disabled-count transfer", busy, 0);
  endtask

  task automatic t_polarity;
    configure(2'b00, 0, 0, 5'b00000);
    check("R8 idle request high when active-low", dreq_o, 1);
    load(2); command(8'h00);
    check("R8 request active-low", dreq_o, 0);
    pulse_pin(0, 1);
    check("R8 active-low read strobe counts", remaining, 1);
    pulse_pin(3, 0);
    check("R8 active-low EOT", last_cause, 2'b10);
    check("R8 ended", busy, 0);
  endtask

  task automatic t_zero_start;
    int d0;
    configure(2'b00, 0, 0, 5'b11111);
    load(0); d0 = n_done; command(8'h00);
    check("R4 zero-count start ends", busy, 0);
    check("R4 zero-count done", n_done - d0, 1);
    check("R12 cause COUNT", last_cause, 2'b01);
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    cyc(3);
    t_reset();
    rst_n = 1; cyc(2);
    t_read8();
    t_bad_cmd();
    t_write16();
    t_eot();
    t_cnt_dis();
    t_polarity();
    t_zero_start();
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end
endmodule